// File: doc/BRIEF.md
# Single-Precision to Bfloat16 Converter and Classifier

This block turns a 32-bit IEEE single-precision bit pattern into a 16-bit bfloat16 pattern. It rounds to nearest with ties going to even. A pattern whose exponent field is all ones is an infinity or a NaN, and it is cut to its upper half without rounding. In the same cycle the block widens a separate bfloat16 input back to single precision by placing it in the upper half, and it classifies that bfloat16 input as NaN, infinity or zero.

A single strobe captures both inputs together. One cycle later every result appears on registered outputs, together with a valid pulse. The outputs keep their values until the next strobe. Denormal bfloat16 values are not handled as numbers; the classifier reports them as zero.

Top module: `bf16_conv`

## Requirements
- R1: `res_vld` is high in exactly the cycle after a cycle with `cvt_stb` high, and low otherwise.
- R2: For a single-precision input whose exponent field (bits 30:23) is not 0xFF, `bf_res` is input bits 31:16 rounded to nearest by the discarded bits 15:0. Above 0x8000 rounds up, below rounds down, and exactly 0x8000 rounds up only when bit 16 is 1 (ties to even).
- R3: For an input whose exponent field is 0xFF, `bf_res` equals input bits 31:16 unchanged. The discarded low bits never change the result.
- R4: When rounding carries a finite value into exponent 0xFF, `bf_res` is the infinity pattern (exponent 0xFF, mantissa 0) and keeps the input sign.
- R5: `f32_res` is `bf_in` in bits 31:16, with bits 15:0 zero.
- R6: `is_nan` is set when `bf_in` bits 14:7 are all ones and bits 6:0 are nonzero.
- R7: `is_inf` is set when `bf_in` bits 14:7 are all ones and bits 6:0 are zero, with either sign.
- R8: `is_zero` is set when `bf_in` bits 14:7 are zero. This covers both signed zeros and every denormal pattern, which are treated as zero.
- R9: Without a strobe, all results hold their last values, whatever the inputs do.
- R10: After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cvt_stb | input | 1 | Captures both inputs in this cycle |
| f32_in | input | 32 | Single-precision pattern to narrow |
| bf_in | input | 16 | Bfloat16 pattern to widen and classify |
| res_vld | output | 1 | Results updated on the previous edge |
| bf_res | output | 16 | Rounded bfloat16 result |
| f32_res | output | 32 | Widened single-precision result |
| is_nan | output | 1 | `bf_in` was a NaN |
| is_inf | output | 1 | `bf_in` was an infinity |
| is_zero | output | 1 | `bf_in` was zero or denormal |

## Verification
Narrowing and classification/widening always happen on the same strobe, each working on its own input. The bench drives unrelated values on `f32_in` and `bf_in` in each strobe cycle, so a mix-up between the two paths shows up. A behavioural model in the bench computes the round-half-even result with integer arithmetic on the discarded half, and it classifies the bfloat16 pattern by its fields. Every output is compared with this model on every clock, and special patterns are also checked against hand-worked values.

// File: rtl/bf16_conv.sv
module bf16_conv (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cvt_stb,
  input  logic [31:0] f32_in,
  input  logic [15:0] bf_in,
  output logic        res_vld,
  output logic [15:0] bf_res,
  output logic [31:0] f32_res,
  output logic        is_nan,
  output logic        is_inf,
  output logic        is_zero
);
  localparam logic [7:0] EXP_ONES = 8'hFF;

  logic        src_special;
  logic [31:0] rnd_sum;
  logic [15:0] bf_next;
  logic [7:0]  bf_exp;
  logic        bf_mant_nz;

  assign src_special = (f32_in[30:23] == EXP_ONES);
  assign rnd_sum     = f32_in + 32'h0000_7FFF + {31'd0, f32_in[16]};
  assign bf_next     = src_special ? f32_in[31:16] : rnd_sum[31:16];
  assign bf_exp      = bf_in[14:7];
  assign bf_mant_nz  = |bf_in[6:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_vld <= 1'b0;
      bf_res  <= '0;
      f32_res <= '0;
      is_nan  <= 1'b0;
      is_inf  <= 1'b0;
      is_zero <= 1'b0;
    end else begin
      res_vld <= cvt_stb;
      if (cvt_stb) begin
        bf_res  <= bf_next;
        f32_res <= {bf_in, 16'h0000};
        is_nan  <= (bf_exp == EXP_ONES) && bf_mant_nz;
        is_inf  <= (bf_exp == EXP_ONES) && !bf_mant_nz;
        is_zero <= (bf_exp == 8'h00);
      end
    end
  end

  // R1
  vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld == $past(cvt_stb));

  // R3
  special_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cvt_stb) && $past(f32_in[30:23]) == EXP_ONES) |-> bf_res == $past(f32_in[31:16]));

  // R2
  exact_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cvt_stb) && $past(f32_in[15:0]) == 16'h0) |-> bf_res == $past(f32_in[31:16]));

  // R4
  sign_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cvt_stb) |-> bf_res[15] == $past(f32_in[31]));

  // R5
  widen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cvt_stb) |-> f32_res == {$past(bf_in), 16'h0000});

  // R6
  class_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({is_nan, is_inf, is_zero}));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cvt_stb) |-> ($stable(bf_res) && $stable(f32_res) && $stable(is_zero)));
endmodule

// File: tb/bf16_conv_tb.sv
module bf16_conv_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cvt_stb = 1'b0;
  logic [31:0] f32_in = '0;
  logic [15:0] bf_in = '0;
  logic        res_vld, is_nan, is_inf, is_zero;
  logic [15:0] bf_res;
  logic [31:0] f32_res;

  int errors = 0;
  int checks = 0;
  bit run_cmp = 1'b0;

  always #5 clk = ~clk;

  bf16_conv u_dut (.clk(clk), .rst_n(rst_n), .cvt_stb(cvt_stb), .f32_in(f32_in),
    .bf_in(bf_in), .res_vld(res_vld), .bf_res(bf_res), .f32_res(f32_res),
    .is_nan(is_nan), .is_inf(is_inf), .is_zero(is_zero));

  function automatic logic [15:0] ref_narrow(input logic [31:0] f);
    int unsigned hi, lo;
    hi = f[31:16];
    lo = f[15:0];
    if (f[30:23] == 8'hFF) return f[31:16];
    if (lo > 32'h8000 || (lo == 32'h8000 && (hi % 2) == 1)) hi = hi + 1;
    return hi[15:0];
  endfunction

  logic        m_vld = 0, m_nan = 0, m_inf = 0, m_zero = 0;
  logic [15:0] m_bf = '0;
  logic [31:0] m_f32 = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_vld <= 0; m_bf <= '0; m_f32 <= '0; m_nan <= 0; m_inf <= 0; m_zero <= 0;
    end else begin
      m_vld <= cvt_stb;
      if (cvt_stb) begin
        m_bf   <= ref_narrow(f32_in);
        m_f32  <= bf_in * 32'd65536;
        m_nan  <= (bf_in[14:7] == 8'd255) && (bf_in[6:0] != 0);
        m_inf  <= (bf_in[14:7] == 8'd255) && (bf_in[6:0] == 0);
        m_zero <= (bf_in[14:7] == 8'd0);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison; cycles without strobe exercise R9 holding
  always @(negedge clk) if (run_cmp) begin
    chk("R1 valid", {31'd0, res_vld}, {31'd0, m_vld});
    chk("R2 narrow", {16'd0, bf_res}, {16'd0, m_bf});
    chk("R5 widen", f32_res, m_f32);
    chk("R6 nan", {31'd0, is_nan}, {31'd0, m_nan});
    chk("R7 inf", {31'd0, is_inf}, {31'd0, m_inf});
    chk("R8 zero", {31'd0, is_zero}, {31'd0, m_zero});
  end

  task automatic apply(input logic [31:0] f, input logic [15:0] b,
                       input logic [15:0] exp_bf, input logic [2:0] exp_cls, input string tag);
    @(negedge clk);
    f32_in = f; bf_in = b; cvt_stb = 1'b1;
    @(negedge clk);
    cvt_stb = 1'b0;
    f32_in = ~f; bf_in = ~b;
    chk({tag, " bf_res"}, {16'd0, bf_res}, {16'd0, exp_bf});
    chk({tag, " class"}, {29'd0, is_nan, is_inf, is_zero}, {29'd0, exp_cls});
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 reset", {res_vld, is_nan, is_inf, is_zero, bf_res, 12'd0}, 32'd0);
    chk("R10 reset f32", f32_res, 32'd0);
    rst_n = 1'b1;
    run_cmp = 1'b1;
    // R2 exact, ties to even, above/below half
    apply(32'h3F80_0000, 16'h3F80, 16'h3F80, 3'b000, "R2 exact");
    apply(32'h3F80_8000, 16'h0000, 16'h3F80, 3'b001, "R2 tie even");
    apply(32'h3F81_8000, 16'h8000, 16'h3F82, 3'b001, "R2 tie odd");
    apply(32'h3F80_8001, 16'h0001, 16'h3F81, 3'b001, "R2 above half / R8 denormal");
    apply(32'hBF80_7FFF, 16'h807F, 16'hBF80, 3'b001, "R2 below half / R8 neg denormal");
    // R3 special patterns truncated
    apply(32'h7FC0_FFFF, 16'h7F80, 16'h7FC0, 3'b010, "R3 nan / R7 inf");
    apply(32'hFF80_FFFF, 16'hFF80, 16'hFF80, 3'b010, "R3 inf kept / R7 neg inf");
    apply(32'h7F81_8000, 16'h7FC1, 16'h7F81, 3'b100, "R3 no tie round / R6 nan");
    // R4 carry into infinity
    apply(32'h7F7F_FFFF, 16'hFF81, 16'h7F80, 3'b100, "R4 pos overflow / R6 neg nan");
    apply(32'hFF7F_8000, 16'h4000, 16'hFF80, 3'b000, "R4 neg tie overflow");
    // R9 idle cycles with moving inputs
    repeat (4) begin
      @(negedge clk);
      f32_in = f32_in + 32'h0123_4567; bf_in = bf_in + 16'h1357;
    end
    // back-to-back strobes with mixed values
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      f32_in = {i[7:0], 8'h7F, i[7:0] ^ 8'h5A, 8'h80} ^ (i * 32'h9E37_79B9);
      bf_in = i[15:0] * 16'h2F1B;
      cvt_stb = (i % 5) != 3;
    end
    @(negedge clk);
    cvt_stb = 1'b0;
    repeat (3) @(negedge clk);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule